// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

A memory-mapped watchdog built on a free-running 32-bit timebase counter. Software reaches it over a plain 32-bit register port (address, write strobe, write data, read strobe, read data). Two arming bits, one in each of the two control/status words, must both be 1 before the watchdog acts on the timebase. Every time the low `INTERVAL_LOG2` bits of the timebase wrap from all ones to zero while the watchdog is running, one expiry takes place.

The first expiry only warns: it sets a pending flag and raises a level interrupt. Software answers by writing 1 to the pending flag, which clears it. If the flag is still set at the following expiry, the block emits a one-cycle reset request and latches a sticky reset-seen flag that software can inspect and clear later. A build-time option can lock the watchdog on once it has been fully armed.

Top module: `tbase_wdt`

## Requirements
- R1: After a synchronous reset all flags and arming bits are 0, `warn_irq_o` and `reset_req_o` are low, and the first read of the timebase (byte offset 0x8) issued in the first cycle out of reset returns 0.
- R2: The timebase at offset 0x8 increments by one on every clock out of reset, whatever the arming state. Writes to offset 0x8 have no effect on it, so two reads in consecutive cycles differ by exactly 1.
- R3: An expiry takes place only while arming bit A (offset 0x0, bit 1) and arming bit B (offset 0x4, bit 0) are both 1. With either bit 0, no flag changes and no reset request appears.
- R4: An expiry is the clock edge at which the low `INTERVAL_LOG2` timebase bits step from all ones to zero. An expiry with the pending flag (offset 0x0, bit 2) clear sets that flag and does not request a reset.
- R5: `warn_irq_o` is high exactly while the pending flag is set and both arming bits are 1.
- R6: An expiry with the pending flag already set drives `reset_req_o` high for exactly one cycle (the cycle after the edge) and sets the reset-seen flag (offset 0x0, bit 3). The pending flag stays set.
- R7: Writing offset 0x0 with bit 2 = 1 clears the pending flag (keepalive), and writing with bit 3 = 1 clears the reset-seen flag. A 0 in either position leaves that flag unchanged. Keepalives issued once per interval prevent any reset request.
- R8: A keepalive written in the same cycle as an expiry is applied first, so that expiry is treated as a first expiry: the pending flag ends set and no reset is requested. A reset-seen clear written in the same cycle as a reset-requesting expiry loses, and the flag ends set.
- R9: The reset-seen flag survives disarming. Clearing arming bit B leaves bit 3 of offset 0x0 set.
- R10: With `ENABLE_ONCE` = 1, once both arming bits are 1 neither can be cleared until reset. Before both are set, each can still be cleared.
- R11: A read strobe captures the addressed word into `rdata_o` at the next edge. `rdata_o` holds its value between read strobes. Offset 0x0 returns {reset-seen, pending, arm A, arm B} in bits 3..0. Offset 0x4 returns arm B in bit 0. All other bits and offsets (including 0xC and any address with bits above 3 set) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the timebase counts these cycles |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; data appears on rdata_o after the next edge |
| rdata_o | output | 32 | Registered read data |
| warn_irq_o | output | 1 | Level interrupt: pending flag set while armed |
| reset_req_o | output | 1 | One-cycle reset request on the second unanswered expiry |

## Verification
Two functions can meet on one clock edge: the software keepalive or reset-seen clear, and the hardware expiry that sets those same flags. The bench follows the timebase with its own model and places a write exactly in the cycle whose edge is an expiry. It does this once with a keepalive against a pending flag, where the expected result is no reset request and the flag re-set. It does it again with a reset-seen clear against a firing expiry, where the expected result is a pulse and the flag still set. A cycle-level model also checks every interrupt, reset-request and read-data value throughout the run.

// File: rtl/tbase_wdt_pkg.sv
package tbase_wdt_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned TB_W   = 32;

    // Bit positions inside the first control/status word (software visible).
    localparam int unsigned BIT_SEEN   = 3;
    localparam int unsigned BIT_PEND   = 2;
    localparam int unsigned BIT_ARM_A  = 1;
    localparam int unsigned BIT_ARM_BM = 0;
    // Bit position inside the second control/status word.
    localparam int unsigned BIT_ARM_B  = 0;

    typedef enum logic [1:0] {
        SEL_CSR0  = 2'd0,
        SEL_CSR1  = 2'd1,
        SEL_TBASE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rst_seen;
        logic pending;
    } wd_flags_t;

    typedef struct packed {
        logic arm_a;
        logic arm_b;
    } wd_arm_t;

    function automatic logic [DATA_W-1:0] csr0_image(input wd_flags_t f, input wd_arm_t a);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_SEEN]   = f.rst_seen;
        v[BIT_PEND]   = f.pending;
        v[BIT_ARM_A]  = a.arm_a;
        v[BIT_ARM_BM] = a.arm_b;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] csr1_image(input wd_arm_t a);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_ARM_B] = a.arm_b;
        return v;
    endfunction

endpackage

// File: rtl/tbase_wdt_counter.sv
module tbase_wdt_counter
    import tbase_wdt_pkg::*;
#(
    parameter int unsigned INTERVAL_LOG2 = 16
) (
    input  logic            clk_i,
    input  logic            rst_i,
    output logic [TB_W-1:0] count_o,
    output logic            wrap_next_o
);

    localparam logic [INTERVAL_LOG2-1:0] LOW_ONES = '1;

    logic [TB_W-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + TB_W'(1);
        end
    end

    // The next edge carries the low field from all ones to zero.
    assign wrap_next_o = (count_q[INTERVAL_LOG2-1:0] == LOW_ONES);
    assign count_o     = count_q;

endmodule

// File: rtl/tbase_wdt_arming.sv
module tbase_wdt_arming
    import tbase_wdt_pkg::*;
#(
    parameter bit ENABLE_ONCE = 1'b0
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    csr0_wr_i,
    input  logic    csr1_wr_i,
    input  logic    arm_a_bit_i,
    input  logic    arm_b_bit_i,
    output wd_arm_t arm_o,
    output logic    running_o
);

    wd_arm_t arm_q;
    wd_arm_t arm_d;
    logic    frozen;

    // In lock mode the live "both armed" state itself is the lock.
    assign frozen = ENABLE_ONCE && arm_q.arm_a && arm_q.arm_b;

    always_comb begin
        arm_d = arm_q;
        if (!frozen) begin
            if (csr0_wr_i) arm_d.arm_a = arm_a_bit_i;
            if (csr1_wr_i) arm_d.arm_b = arm_b_bit_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            arm_q <= '0;
        end else begin
            arm_q <= arm_d;
        end
    end

    assign arm_o     = arm_q;
    assign running_o = arm_q.arm_a & arm_q.arm_b;

    generate
        if (ENABLE_ONCE) begin : g_lock_chk
            // R10: a fully armed watchdog stays armed.
            a_r10_stays_armed: assert property (@(posedge clk_i) disable iff (rst_i)
                running_o |=> running_o);
        end
    endgenerate

endmodule

// File: rtl/tbase_wdt_flags.sv
module tbase_wdt_flags
    import tbase_wdt_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      running_i,
    input  logic      wrap_next_i,
    input  logic      csr0_wr_i,
    input  logic      pend_bit_i,
    input  logic      seen_bit_i,
    output wd_flags_t flags_o,
    output logic      fire_o
);

    wd_flags_t flags_q;
    wd_flags_t flags_d;
    logic      fire_q;
    logic      expiry;
    logic      kick;
    logic      clear_seen;
    logic      pend_left;
    logic      fire_d;

    always_comb begin
        expiry     = running_i & wrap_next_i;
        kick       = csr0_wr_i & pend_bit_i;
        clear_seen = csr0_wr_i & seen_bit_i;
        // A same-cycle keepalive is served before the expiry is judged.
        pend_left  = flags_q.pending & ~kick;
        fire_d     = expiry & pend_left;
        flags_d.pending  = expiry | pend_left;
        // Hardware setting wins over a same-cycle software clear.
        flags_d.rst_seen = fire_d | (flags_q.rst_seen & ~clear_seen);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flags_q <= '0;
            fire_q  <= 1'b0;
        end else begin
            flags_q <= flags_d;
            fire_q  <= fire_d;
        end
    end

    assign flags_o = flags_q;
    assign fire_o  = fire_q;

    // R6: every reset request is accompanied by the latched status.
    a_r6_fire_latched: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |-> flags_o.rst_seen);

    // R6: the request lasts a single cycle.
    a_r6_single_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |=> !fire_o);

    // R4: the first expiry only arms the pending flag.
    a_r4_first_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(flags_o.pending) |-> !fire_o);

    // R3: nothing advances while disarmed.
    a_r3_idle_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        !running_i |=> (!fire_o && !$rose(flags_o.pending)));

    // R9: the status flag only drops on an explicit clear.
    a_r9_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (flags_o.rst_seen && !(csr0_wr_i && seen_bit_i)) |=> flags_o.rst_seen);

endmodule

// File: rtl/tbase_wdt.sv
module tbase_wdt
    import tbase_wdt_pkg::*;
#(
    parameter int unsigned INTERVAL_LOG2 = 16,
    parameter bit          ENABLE_ONCE   = 1'b0,
    parameter int unsigned ADDR_W        = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              warn_irq_o,
    output logic              reset_req_o
);

    reg_sel_e          sel;
    logic              csr0_wr;
    logic              csr1_wr;
    logic [TB_W-1:0]   tb_count;
    logic              wrap_next;
    wd_arm_t           arm;
    logic              running;
    wd_flags_t         flags;
    logic              fire;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_bits;

    // Word decode: bits above the register window must be zero.
    always_comb begin
        if (addr_i[ADDR_W-1:4] == '0) begin
            sel = reg_sel_e'(addr_i[3:2]);
        end else begin
            sel = SEL_NONE;
        end
    end

    assign csr0_wr     = wr_en_i && (sel == SEL_CSR0);
    assign csr1_wr     = wr_en_i && (sel == SEL_CSR1);
    assign unused_bits = ^{wdata_i[DATA_W-1:4], addr_i[1:0]};

    tbase_wdt_counter #(
        .INTERVAL_LOG2 (INTERVAL_LOG2)
    ) u_counter (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .count_o     (tb_count),
        .wrap_next_o (wrap_next)
    );

    tbase_wdt_arming #(
        .ENABLE_ONCE (ENABLE_ONCE)
    ) u_arming (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .csr0_wr_i   (csr0_wr),
        .csr1_wr_i   (csr1_wr),
        .arm_a_bit_i (wdata_i[BIT_ARM_A]),
        .arm_b_bit_i (wdata_i[BIT_ARM_B]),
        .arm_o       (arm),
        .running_o   (running)
    );

    tbase_wdt_flags u_flags (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .running_i   (running),
        .wrap_next_i (wrap_next),
        .csr0_wr_i   (csr0_wr),
        .pend_bit_i  (wdata_i[BIT_PEND]),
        .seen_bit_i  (wdata_i[BIT_SEEN]),
        .flags_o     (flags),
        .fire_o      (fire)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            unique case (sel)
                SEL_CSR0:  rdata_q <= csr0_image(flags, arm);
                SEL_CSR1:  rdata_q <= csr1_image(arm);
                SEL_TBASE: rdata_q <= tb_count;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign rdata_o     = rdata_q;
    assign warn_irq_o  = flags.pending & running;
    assign reset_req_o = fire;

    // R4: a reset request only follows an interval wrap of the timebase.
    a_r4_fire_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        reset_req_o |-> (tb_count[INTERVAL_LOG2-1:0] == '0));

    // R11: read data only moves after a read strobe.
    a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rd_en_i) |-> $stable(rdata_o));

endmodule

// File: tb/tbase_wdt_tb.sv
module tbase_wdt_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int unsigned N          = 4;
    localparam logic [31:0] LOW_MASK   = (32'd1 << N) - 32'd1;

    logic        clk   = 1'b0;
    logic        rst   = 1'b1;
    logic [7:0]  addr  = '0;
    logic        wr    = 1'b0;
    logic        wr_l  = 1'b0;
    logic        rd    = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_l;
    logic        irq, irq_l, rreq, rreq_l;

    int checks   = 0;
    int failures = 0;
    int pulses   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbase_wdt #(.INTERVAL_LOG2(N), .ENABLE_ONCE(1'b0), .ADDR_W(8)) u_dut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
        .rd_en_i(rd), .rdata_o(rdata), .warn_irq_o(irq), .reset_req_o(rreq));

    tbase_wdt #(.INTERVAL_LOG2(N), .ENABLE_ONCE(1'b1), .ADDR_W(8)) u_dut_lock (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_l), .wdata_i(wdata),
        .rd_en_i(rd), .rdata_o(rdata_l), .warn_irq_o(irq_l), .reset_req_o(rreq_l));

    // Behavioural reference for the unlocked instance.
    logic [31:0] m_tb = '0, m_rdata = '0;
    bit m_arm_a = 0, m_arm_b = 0, m_pend = 0, m_seen = 0, m_pulse = 0;
    bit t_run, t_exp, t_kick, t_clr, t_left, t_fire, t_w0, t_w1;
    int t_word;

    always @(posedge clk) begin
        if (rst) begin
            m_tb = '0; m_rdata = '0;
            m_arm_a = 0; m_arm_b = 0; m_pend = 0; m_seen = 0; m_pulse = 0;
        end else begin
            t_word = (addr[7:4] == 4'd0) ? int'(addr[3:2]) : 3;
            t_w0   = wr && (t_word == 0);
            t_w1   = wr && (t_word == 1);
            t_run  = m_arm_a && m_arm_b;
            t_exp  = t_run && ((m_tb & LOW_MASK) == LOW_MASK);
            t_kick = t_w0 && wdata[2];
            t_clr  = t_w0 && wdata[3];
            t_left = m_pend && !t_kick;
            t_fire = t_exp && t_left;
            if (rd) begin
                case (t_word)
                    0: m_rdata = {28'd0, m_seen, m_pend, m_arm_a, m_arm_b};
                    1: m_rdata = {31'd0, m_arm_b};
                    2: m_rdata = m_tb;
                    default: m_rdata = '0;
                endcase
            end
            m_seen  = t_fire || (m_seen && !t_clr);
            m_pend  = t_exp || t_left;
            m_pulse = t_fire;
            if (t_w0) m_arm_a = wdata[1];
            if (t_w1) m_arm_b = wdata[0];
            m_tb = m_tb + 32'd1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R5 irq vs model", {31'd0, irq}, {31'd0, m_pend && m_arm_a && m_arm_b});
            check("R6 reset_req vs model", {31'd0, rreq}, {31'd0, m_pulse});
            check("R11 rdata vs model", rdata, m_rdata);
            if (rreq) pulses++;
        end
    end

    task automatic wr_reg(input bit lock, input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d;
        if (lock) wr_l = 1'b1; else wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wr_l = 1'b0;
    endtask

    task automatic rd_reg(input bit lock, input logic [7:0] a, output logic [31:0] v);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = lock ? rdata_l : rdata;
    endtask

    task automatic wait_low(input logic [31:0] v);
        while ((m_tb & LOW_MASK) != v) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, v1, v2;
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'd0, irq}, 32'd0);
        check("R1 reset_req in reset", {31'd0, rreq}, 32'd0);
        rst = 1'b0;
        rd_reg(0, 8'h08, v);  check("R1 timebase starts at zero", v, 32'd0);
        rd_reg(0, 8'h00, v);  check("R1 csr0 clear", v, 32'd0);
        rd_reg(0, 8'h04, v);  check("R1 csr1 clear", v, 32'd0);

        // R2: free running, writes ignored
        rd_reg(0, 8'h08, v1);
        rd_reg(0, 8'h08, v2);
        check("R2 consecutive reads step by one", v2 - v1, 32'd1);
        wr_reg(0, 8'h08, 32'h0);
        rd_reg(0, 8'h08, v);
        check("R2 write to timebase ignored", v, v2 + 32'd2);

        // R3: one arming bit alone does nothing
        pulses = 0;
        wr_reg(0, 8'h00, 32'h2);
        repeat (40) @(negedge clk);
        check("R3 only arm A: no irq", {31'd0, irq}, 32'd0);
        rd_reg(0, 8'h00, v);  check("R3 only arm A: csr0", v, 32'h2);
        wr_reg(0, 8'h00, 32'h0);
        wr_reg(0, 8'h04, 32'h1);
        repeat (40) @(negedge clk);
        check("R3 only arm B: no pulse", pulses, 0);
        rd_reg(0, 8'h00, v);  check("R11 csr0 mirrors arm B", v, 32'h1);
        rd_reg(0, 8'h04, v);  check("R11 csr1 arm B", v, 32'h1);
        rd_reg(0, 8'h0C, v);  check("R11 unmapped 0xC", v, 32'h0);
        rd_reg(0, 8'h40, v);  check("R11 high address", v, 32'h0);

        // R4 / R5: first expiry
        wr_reg(0, 8'h00, 32'h2);
        wait_low(LOW_MASK);
        @(negedge clk);
        check("R4 first expiry raises irq", {31'd0, irq}, 32'd1);
        check("R4 first expiry no reset", {31'd0, rreq}, 32'd0);
        rd_reg(0, 8'h00, v);  check("R4 pending set", v, 32'h7);

        // R6: second expiry
        wait_low(LOW_MASK);
        @(negedge clk);
        check("R6 pulse high", {31'd0, rreq}, 32'd1);
        @(negedge clk);
        check("R6 pulse one cycle", {31'd0, rreq}, 32'd0);
        rd_reg(0, 8'h00, v);  check("R6 status latched", v, 32'hF);

        // R7: keepalive
        wr_reg(0, 8'h00, 32'h6);
        check("R7 keepalive drops irq", {31'd0, irq}, 32'd0);
        rd_reg(0, 8'h00, v);  check("R7 pending cleared", v, 32'hB);
        wr_reg(0, 8'h00, 32'h2);
        rd_reg(0, 8'h00, v);  check("R7 zero bits leave flags", v, 32'hB);
        pulses = 0;
        for (int i = 0; i < 5; i++) begin
            wait_low(32'd5);
            wr_reg(0, 8'h00, 32'h6);
        end
        check("R7 periodic keepalive no pulse", pulses, 0);

        // R8: collisions on the expiry edge
        wait_low(LOW_MASK);
        @(negedge clk);
        wait_low(LOW_MASK);
        wr_reg(0, 8'h00, 32'h6);
        check("R8 keepalive at expiry: no pulse", {31'd0, rreq}, 32'd0);
        check("R8 keepalive at expiry: re-armed", {31'd0, irq}, 32'd1);
        wait_low(LOW_MASK);
        wr_reg(0, 8'h00, 32'hA);
        check("R8 clear at firing expiry: pulse", {31'd0, rreq}, 32'd1);
        rd_reg(0, 8'h00, v);  check("R8 status set wins", v, 32'hF);

        // R9: status survives disarm
        wr_reg(0, 8'h04, 32'h0);
        rd_reg(0, 8'h00, v);  check("R9 status kept when disarmed", v, 32'hE);
        check("R5 irq off when disarmed", {31'd0, irq}, 32'd0);
        pulses = 0;
        repeat (40) @(negedge clk);
        check("R3 disarmed no pulse", pulses, 0);
        wr_reg(0, 8'h00, 32'hC);
        rd_reg(0, 8'h00, v);  check("R7 both flags cleared", v, 32'h0);

        // R10: lock instance
        wr_reg(1, 8'h00, 32'h2);
        wr_reg(1, 8'h00, 32'h0);
        rd_reg(1, 8'h00, v);  check("R10 clear before full arm", v & 32'h3, 32'h0);
        wr_reg(1, 8'h00, 32'h2);
        wr_reg(1, 8'h04, 32'h1);
        wr_reg(1, 8'h00, 32'h0);
        wr_reg(1, 8'h04, 32'h0);
        rd_reg(1, 8'h00, v);  check("R10 arming locked csr0", v & 32'h3, 32'h3);
        rd_reg(1, 8'h04, v);  check("R10 arming locked csr1", v, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule